// File: doc/BRIEF.md
# Shared-Band Radio Coexistence Arbiter

This block decides, slot by slot, whether a neighbouring short-range radio may use the 2.4 GHz band that it shares with the local wireless LAN. The neighbour raises an asynchronous request line for each slot in which it wants the medium. In three-line signalling it also drives a priority line. The block answers on a single deny line: high blocks the slot, low lets it go ahead. The local LAN side supplies its transmit-busy, receive-busy and high-priority flags on the block's clock.

The neighbour's lines pass through two-flop synchronisers. The block then takes a decision at the first synchronised cycle of each request and holds it until the request drops, so a grant never changes mid-slot. A configuration bit selects two-line or three-line signalling to suit the attached device. An enable bit turns arbitration off; while it is off, every slot is granted. An antenna-select output normally follows the arbitration result. A bypass bit can instead drive it from a manual level in either signalling mode.

Top module: `coex_arbiter`

## Requirements
- R1: After reset, with no request pending, `wl_deny` is 0 and, when enabled without bypass, `ant_sel` is 0.
- R2: A request edge on `bt_req_async` applied between clock edges affects `wl_deny` after the third rising clock edge, not before (two synchroniser stages plus the decision register).
- R3: In two-line mode (`cfg_three_wire`=0) a slot is denied exactly when `wl_tx_busy` or `wl_rx_busy` is 1 at the decision cycle. `bt_pri_async` and `wl_hi_pri` have no effect.
- R4: In three-line mode (`cfg_three_wire`=1), a request with the priority line at 0 is denied exactly when `wl_tx_busy` or `wl_rx_busy` is 1.
- R5: In three-line mode, a request with the priority line at 1 is denied exactly when `wl_hi_pri` is 1, whatever the busy flags are.
- R6: While the synchronised request stays high and the block stays enabled, `wl_deny` does not change, even when the LAN flags, the priority line or the mode change.
- R7: When the request falls, `wl_deny` returns to 0 after the third rising edge.
- R8: With `cfg_en`=0, `wl_deny` is 0. Clearing `cfg_en` mid-slot drops `wl_deny` after the next rising edge.
- R9: When enabled without bypass, `ant_sel` is 1 only while a request slot is granted; otherwise it is 0. `ant_sel` and `wl_deny` are never both 1 from arbitration.
- R10: When enabled with `cfg_ant_bypass`=1, `ant_sel` equals `cfg_ant_manual` in either mode, independent of arbitration.
- R11: With `cfg_en`=0, `ant_sel` equals `cfg_ant_default`.
- R12: Setting `cfg_en` again during a slot that is already in progress issues no new decision. `wl_deny` stays 0 and `ant_sel` stays 0 until a fresh request edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Arbitration enable |
| cfg_three_wire | input | 1 | 1 selects three-line signalling, 0 two-line |
| cfg_ant_bypass | input | 1 | 1 drives antenna select from the manual level |
| cfg_ant_manual | input | 1 | Antenna level used under bypass |
| cfg_ant_default | input | 1 | Antenna level used while disabled |
| bt_req_async | input | 1 | Neighbour radio slot request, asynchronous |
| bt_pri_async | input | 1 | Neighbour slot priority, asynchronous, three-line only |
| wl_tx_busy | input | 1 | Local LAN transmitting |
| wl_rx_busy | input | 1 | Local LAN receiving |
| wl_hi_pri | input | 1 | Local LAN traffic is high priority |
| wl_deny | output | 1 | 1 blocks the requested slot, 0 grants it |
| ant_sel | output | 1 | Antenna select, 1 gives the antenna to the neighbour radio |

## Verification
The properties assume that the LAN flags and configuration bits are synchronous to `clk`. They also assume that the priority line settles no later than the request edge, because both lines pass through matching synchronisers and the priority is sampled in the same cycle as the request edge. The stimulus changes every input at the falling clock edge. It puts the priority and the LAN flags in place together with, or before, the request. It holds each level for several cycles, so every decision cycle sees settled values. The hold property covers only the enabled part of a slot, since a disable is allowed to override a decision at once.

// File: rtl/coex_pkg.sv
package coex_pkg;

  typedef enum logic {
    LINK_TWO   = 1'b0,
    LINK_THREE = 1'b1
  } link_mode_e;

  typedef struct packed {
    logic tx_busy;
    logic rx_busy;
    logic hi_pri;
  } lan_state_t;

  // Deny decision for one slot, taken at the request edge.
  function automatic logic slot_denied(link_mode_e mode, logic pri, lan_state_t lan);
    logic busy;
    busy = lan.tx_busy | lan.rx_busy;
    if (mode == LINK_THREE && pri) begin
      return lan.hi_pri;
    end
    return busy;
  endfunction

endpackage

// File: rtl/coex_rst_sync.sv
module coex_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/coex_sync.sv
module coex_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = d_async;
      end else begin : g_next
        always_comb stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d[s];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/coex_decide.sv
module coex_decide
  import coex_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  link_mode_e mode,
  input  logic       req_s,
  input  logic       pri_s,
  input  lan_state_t lan,
  output logic       deny_q,
  output logic       grant_q
);
  logic req_d;
  logic req_rise;
  logic deny_n;
  logic grant_n;
  logic verdict;

  assign req_rise = req_s & ~req_d;
  assign verdict  = slot_denied(mode, pri_s, lan);

  // next-state
  always_comb begin
    deny_n  = deny_q;
    grant_n = grant_q;
    if (!en || !req_s) begin
      deny_n  = 1'b0;
      grant_n = 1'b0;
    end else if (req_rise) begin
      deny_n  = verdict;
      grant_n = ~verdict;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d   <= 1'b0;
      deny_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      req_d   <= req_s;
      deny_q  <= deny_n;
      grant_q <= grant_n;
    end
  end

  // R6
  hold_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_s && req_d && en) |=> $stable(deny_q));

  // R7
  release_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_s |=> !deny_q);

  // R8
  off_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!deny_q && !grant_q));

  // R9
  exclusive_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(deny_q && grant_q));

  // R5
  high_pri_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && en && mode == LINK_THREE && pri_s) |=> (deny_q == $past(lan.hi_pri)));

  // R12
  no_decision_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!deny_q && !grant_q && req_s && req_d) |=> (!deny_q && !grant_q));
endmodule

// File: rtl/coex_ant.sv
module coex_ant (
  input  logic en,
  input  logic bypass,
  input  logic manual_lvl,
  input  logic default_lvl,
  input  logic granted,
  output logic ant_sel
);
  always_comb begin
    if (!en) begin
      ant_sel = default_lvl;
    end else if (bypass) begin
      ant_sel = manual_lvl;
    end else begin
      ant_sel = granted;
    end
  end
endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter
  import coex_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic cfg_three_wire,
  input  logic cfg_ant_bypass,
  input  logic cfg_ant_manual,
  input  logic cfg_ant_default,
  input  logic bt_req_async,
  input  logic bt_pri_async,
  input  logic wl_tx_busy,
  input  logic wl_rx_busy,
  input  logic wl_hi_pri,
  output logic wl_deny,
  output logic ant_sel
);
  localparam int NUM_ASYNC = 2;

  logic                 rst_n_int;
  logic [NUM_ASYNC-1:0] bt_async;
  logic [NUM_ASYNC-1:0] bt_sync;
  logic                 deny_q;
  logic                 grant_q;
  link_mode_e           mode;
  lan_state_t           lan;

  assign bt_async = {bt_pri_async, bt_req_async};
  assign mode     = link_mode_e'(cfg_three_wire);
  assign lan      = '{tx_busy: wl_tx_busy, rx_busy: wl_rx_busy, hi_pri: wl_hi_pri};

  coex_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  coex_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .d_async (bt_async),
    .d_sync  (bt_sync)
  );

  coex_decide u_decide (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (cfg_en),
    .mode    (mode),
    .req_s   (bt_sync[0]),
    .pri_s   (bt_sync[1]),
    .lan     (lan),
    .deny_q  (deny_q),
    .grant_q (grant_q)
  );

  coex_ant u_ant (
    .en          (cfg_en),
    .bypass      (cfg_ant_bypass),
    .manual_lvl  (cfg_ant_manual),
    .default_lvl (cfg_ant_default),
    .granted     (grant_q),
    .ant_sel     (ant_sel)
  );

  assign wl_deny = deny_q;

  // R10
  bypass_level_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cfg_en && cfg_ant_bypass) |-> (ant_sel == cfg_ant_manual));

  // R11
  off_antenna_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cfg_en |-> (ant_sel == cfg_ant_default));
endmodule

// File: tb/tb_coex_arbiter.sv
module tb_coex_arbiter;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_en, cfg_three_wire, cfg_ant_bypass, cfg_ant_manual, cfg_ant_default;
  logic bt_req_async, bt_pri_async, wl_tx_busy, wl_rx_busy, wl_hi_pri;
  logic wl_deny, ant_sel;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  coex_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_three_wire(cfg_three_wire),
    .cfg_ant_bypass(cfg_ant_bypass), .cfg_ant_manual(cfg_ant_manual),
    .cfg_ant_default(cfg_ant_default), .bt_req_async(bt_req_async),
    .bt_pri_async(bt_pri_async), .wl_tx_busy(wl_tx_busy), .wl_rx_busy(wl_rx_busy),
    .wl_hi_pri(wl_hi_pri), .wl_deny(wl_deny), .ant_sel(ant_sel)
  );

  // Bits: [6] en, [5] three-line, [4] pri, [3] tx, [2] rx, [1] lan hi, [0] expected deny
  localparam int NVEC = 14;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b1000000, 7'b1001001, 7'b1010101, 7'b1010010, 7'b1010000,
    7'b1100000, 7'b1101001, 7'b1100111, 7'b1100010,
    7'b1111100, 7'b1110011, 7'b1111011,
    7'b0101110, 7'b0001000
  };
  localparam string VTAG [NVEC] = '{
    "R3", "R3", "R3", "R3", "R3", "R4", "R4", "R4", "R4",
    "R5", "R5", "R5", "R8", "R8"
  };

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_en = 1'b1; cfg_three_wire = 1'b0; cfg_ant_bypass = 1'b0;
    cfg_ant_manual = 1'b0; cfg_ant_default = 1'b0;
    bt_req_async = 1'b0; bt_pri_async = 1'b0;
    wl_tx_busy = 1'b0; wl_rx_busy = 1'b0; wl_hi_pri = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(5);
    check("R1", "deny after reset", wl_deny, 1'b0);
    check("R1", "antenna after reset", ant_sel, 1'b0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [6:0] v;
      v = VEC[i];
      cfg_en = v[6]; cfg_three_wire = v[5]; bt_pri_async = v[4];
      wl_tx_busy = v[3]; wl_rx_busy = v[2]; wl_hi_pri = v[1];
      bt_req_async = 1'b1;
      settle(4);
      check(VTAG[i], "deny in slot", wl_deny, v[0]);
      check(v[6] ? "R9" : "R11", "antenna in slot", ant_sel, v[6] ? ~v[0] : 1'b0);
      bt_req_async = 1'b0;
      settle(4);
      check("R7", "deny after slot", wl_deny, 1'b0);
      check("R9", "antenna after slot", ant_sel, 1'b0);
    end

    // R2 latency and R6 hold, R7 release timing
    cfg_en = 1'b1; cfg_three_wire = 1'b0; bt_pri_async = 1'b0;
    wl_tx_busy = 1'b1; wl_rx_busy = 1'b0; wl_hi_pri = 1'b0;
    bt_req_async = 1'b1;
    settle(2);
    check("R2", "deny before third edge", wl_deny, 1'b0);
    settle(1);
    check("R2", "deny at third edge", wl_deny, 1'b1);
    wl_tx_busy = 1'b0; cfg_three_wire = 1'b1; bt_pri_async = 1'b1;
    settle(6);
    check("R6", "deny held mid-slot", wl_deny, 1'b1);
    check("R6", "antenna held mid-slot", ant_sel, 1'b0);
    bt_req_async = 1'b0;
    settle(2);
    check("R7", "deny before third edge after drop", wl_deny, 1'b1);
    settle(1);
    check("R7", "deny released at third edge", wl_deny, 1'b0);
    bt_pri_async = 1'b0;
    settle(3);

    // R8 disable mid-slot, R11 default antenna, R12 re-enable
    cfg_three_wire = 1'b0; wl_rx_busy = 1'b1; cfg_ant_default = 1'b1;
    bt_req_async = 1'b1;
    settle(4);
    check("R3", "deny before disable", wl_deny, 1'b1);
    cfg_en = 1'b0;
    settle(1);
    check("R8", "deny dropped on disable", wl_deny, 1'b0);
    check("R11", "antenna default on disable", ant_sel, 1'b1);
    cfg_en = 1'b1;
    settle(5);
    check("R12", "no deny after re-enable mid-slot", wl_deny, 1'b0);
    check("R12", "no grant after re-enable mid-slot", ant_sel, 1'b0);
    bt_req_async = 1'b0; wl_rx_busy = 1'b0;
    settle(4);

    // R10 bypass
    cfg_ant_bypass = 1'b1; cfg_ant_manual = 1'b1; wl_tx_busy = 1'b1;
    bt_req_async = 1'b1;
    settle(4);
    check("R10", "deny under bypass", wl_deny, 1'b1);
    check("R10", "manual high under bypass", ant_sel, 1'b1);
    cfg_ant_manual = 1'b0;
    settle(1);
    check("R10", "manual low under bypass", ant_sel, 1'b0);
    bt_req_async = 1'b0;
    cfg_ant_manual = 1'b1; cfg_three_wire = 1'b1; wl_tx_busy = 1'b0;
    settle(4);
    check("R10", "manual level idle three-line", ant_sel, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule